// File: doc/BRIEF.md
# Dual-Chain LCD Segment Column Driver

This block takes serial display data for 40 LCD segment columns and turns it into one drive-rail choice per column. Data enters through two independent 20-stage shift chains. Each chain has its own serial input and its own serial output, and both chains advance on the same shift clock. Tying the first chain's serial output to the second chain's serial input makes a single 40-stage chain. The second chain's serial output feeds the next driver when several are cascaded across a wider panel.

A level-sensitive load input copies the chain contents into a bank of output latches. For each column, the latched bit and a frame-alternation input together select one of four bias rails. The block reports that choice as a 2-bit code. Rail voltages, level shifting and pad behaviour are handled elsewhere.

The whole block runs on one system clock `clk`. The shift clock `shiftClk` is sampled as an ordinary input, and the block acts on its high-to-low transitions.

Top module: `lcd_seg_driver`

## Requirements
- R1: `serInA` enters column 1, and each shift moves column k to column k+1 up to column 20. `serInB` enters column 21 in the same way and moves up to column 40. Column c (1..40) drives `railCode[2c-1:2c-2]`.
- R2: Each high-to-low transition of `shiftClk`, seen on two successive rising edges of `clk`, advances both chains by exactly one position, using the serial inputs sampled at the second edge. A rising transition of `shiftClk`, or holding it at either level, moves nothing.
- R3: `serOutA` shows column 20. A bit shifted into `serInA` appears on `serOutA` after 20 shifts.
- R4: `serOutB` shows column 40. When `serOutA` is tied to `serInB`, the two chains act as one 40-stage chain, and a bit appears on `serOutB` 40 shifts after it enters `serInA`.
- R5: While `loadEn` is high, the output latches take the current chain contents on every `clk` edge, so they follow the chains with one cycle of lag.
- R6: While `loadEn` is low, the output latches keep their value. `railCode` then changes only when `altFrame` changes.
- R7: A latched 1 gives code 2'b00 (V1, highest rail) when `altFrame` is 0, and code 2'b11 (V4, lowest rail) when `altFrame` is 1.
- R8: A latched 0 gives code 2'b01 (V2) when `altFrame` is 0, and code 2'b10 (V3) when `altFrame` is 1.
- R9: When `rstN` is low at a `clk` edge, that edge clears both chains, the latches and the shift-clock edge detector to 0. After reset, every column shows 2'b01 with `altFrame` at 0, and 2'b10 with `altFrame` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| shiftClk | input | 1 | Shift clock; its falling transitions advance the chains |
| serInA | input | 1 | Serial data into column 1 |
| serInB | input | 1 | Serial data into column 21 |
| loadEn | input | 1 | Latch enable; high makes the latches follow the chains |
| altFrame | input | 1 | Frame-alternation input |
| serOutA | output | 1 | Column 20 contents (end of first chain) |
| serOutB | output | 1 | Column 40 contents (end of second chain) |
| railCode | output | 80 | Two bits per column selecting V1..V4 |

## Verification
The hardest case to reach from the ports is the one where the latches are open and the chains advance at the same time. On the edge that shifts, the latches must capture the contents from before the shift, and on the following edge the contents from after it. The stimulus holds `loadEn` high across complete shift sequences and checks `railCode` one cycle after each shift.

A second hard case is telling a real falling transition apart from a rise or a long held level. To cover it, the bench parks `shiftClk` high for several cycles, opens the latches, and confirms that the columns did not move before it lets the clock fall.

Chained mode is exercised by tying `serOutA` to `serInB` inside the bench and shifting a 40-bit pattern through both chains.

// File: rtl/segdrv_pkg.sv
`timescale 1ns/1ps
package segdrv_pkg;

  // Strobes the control issues to the datapath each clk cycle.
  typedef struct packed {
    logic shiftStb;    // advance both chains one position
    logic captureStb;  // copy chain contents into output latches
  } segStrobe_t;

  // Bias rail selection, V1 highest to V4 lowest.
  typedef enum logic [1:0] {
    RAIL_V1 = 2'b00,
    RAIL_V2 = 2'b01,
    RAIL_V3 = 2'b10,
    RAIL_V4 = 2'b11
  } rail_e;

  function automatic rail_e pickRail(input logic dataBit, input logic alt);
    rail_e sel;
    case ({dataBit, alt})
      2'b10:   sel = RAIL_V1;
      2'b11:   sel = RAIL_V4;
      2'b01:   sel = RAIL_V3;
      default: sel = RAIL_V2;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/segdrv_ctrl.sv
`timescale 1ns/1ps
module segdrv_ctrl
  import segdrv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       shiftClk,
  input  logic       loadEn,
  output segStrobe_t strobe
);

  logic shiftClkQ;

  // Remember last sampled shift clock to find high-to-low transitions.
  always_ff @(posedge clk) begin
    if (!rstN) shiftClkQ <= 1'b0;
    else       shiftClkQ <= shiftClk;
  end

  always_comb begin
    strobe.shiftStb   = shiftClkQ & ~shiftClk;
    strobe.captureStb = loadEn;
  end

endmodule

// File: rtl/segdrv_datapath.sv
`timescale 1ns/1ps
module segdrv_datapath
  import segdrv_pkg::*;
#(
  parameter int CHAIN_LEN  = 20,
  parameter int NUM_CHAINS = 2,
  localparam int COLS      = CHAIN_LEN * NUM_CHAINS,
  localparam int CODE_W    = 2 * COLS
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  segStrobe_t            strobe,
  input  logic [NUM_CHAINS-1:0] serIn,
  input  logic                  altFrame,
  output logic [NUM_CHAINS-1:0] serOut,
  output logic [CODE_W-1:0]     railCode
);

  logic [COLS-1:0] chainBits;
  logic [COLS-1:0] latched;

  // One shift chain per serial input; index 0 is the entry column.
  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    logic [CHAIN_LEN-1:0] stage;

    always_ff @(posedge clk) begin
      if (!rstN)                stage <= '0;
      else if (strobe.shiftStb) stage <= {stage[CHAIN_LEN-2:0], serIn[c]};
    end

    assign serOut[c] = stage[CHAIN_LEN-1];
    assign chainBits[c*CHAIN_LEN +: CHAIN_LEN] = stage;
  end

  // Output latches: follow chains while capture strobe is high.
  always_ff @(posedge clk) begin
    if (!rstN)                  latched <= '0;
    else if (strobe.captureStb) latched <= chainBits;
  end

  // Per-column rail selection from latched bit and alternation input.
  for (genvar k = 0; k < COLS; k++) begin : g_rail
    assign railCode[2*k +: 2] = pickRail(latched[k], altFrame);
  end

endmodule

// File: rtl/lcd_seg_driver.sv
`timescale 1ns/1ps
module lcd_seg_driver
  import segdrv_pkg::*;
#(
  parameter int CHAIN_LEN = 20,
  localparam int NUM_CHAINS = 2,
  localparam int CODE_W     = 2 * CHAIN_LEN * NUM_CHAINS
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftClk,
  input  logic              serInA,
  input  logic              serInB,
  input  logic              loadEn,
  input  logic              altFrame,
  output logic              serOutA,
  output logic              serOutB,
  output logic [CODE_W-1:0] railCode
);

  segStrobe_t            strobe;
  logic [NUM_CHAINS-1:0] serOutVec;

  segdrv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .shiftClk (shiftClk),
    .loadEn   (loadEn),
    .strobe   (strobe)
  );

  segdrv_datapath #(
    .CHAIN_LEN  (CHAIN_LEN),
    .NUM_CHAINS (NUM_CHAINS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .serIn    ({serInB, serInA}),
    .altFrame (altFrame),
    .serOut   (serOutVec),
    .railCode (railCode)
  );

  assign serOutA = serOutVec[0];
  assign serOutB = serOutVec[1];

endmodule

// File: rtl/lcd_seg_driver_chk.sv
`timescale 1ns/1ps
module lcd_seg_driver_chk #(
  parameter int CHAIN_LEN = 20,
  localparam int COLS     = 2 * CHAIN_LEN,
  localparam int CODE_W   = 2 * COLS
)(
  input logic              clk,
  input logic              rstN,
  input logic              shiftClk,
  input logic              loadEn,
  input logic              altFrame,
  input logic              serOutA,
  input logic              serOutB,
  input logic [CODE_W-1:0] railCode
);

  AST_NO_SHIFT_WITHOUT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !($past(shiftClk, 2) && !$past(shiftClk)))
      |-> ($stable(serOutA) && $stable(serOutB))); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(loadEn) && $stable(altFrame))
      |-> $stable(railCode)); // R6

  AST_RESET_CLEARS_TAPS: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!serOutA && !serOutB)); // R9

  AST_RESET_RAILS: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (railCode == {COLS{altFrame, !altFrame}})); // R9

  for (genvar i = 0; i < COLS; i++) begin : g_alt
    AST_RAIL_HIGH_BIT: assert property (@(posedge clk) disable iff (!rstN)
      railCode[2*i+1] == altFrame); // R7
  end

endmodule

bind lcd_seg_driver lcd_seg_driver_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .shiftClk (shiftClk),
  .loadEn   (loadEn),
  .altFrame (altFrame),
  .serOutA  (serOutA),
  .serOutB  (serOutB),
  .railCode (railCode)
);

// File: tb/test_lcd_seg_driver.sv
`timescale 1ns/1ps
module test_lcd_seg_driver;

  localparam int LEN = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftClk = 1'b0;
  logic serInA = 1'b0;
  logic serInBDrv = 1'b0;
  logic chained = 1'b0;
  logic loadEn = 1'b0;
  logic altFrame = 1'b0;
  logic serInB;
  logic serOutA, serOutB;
  logic [79:0] railCode;

  assign serInB = chained ? serOutA : serInBDrv;

  always #5 clk = ~clk;

  lcd_seg_driver i_lcd_seg_driver (
    .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .serInA(serInA),
    .serInB(serInB), .loadEn(loadEn), .altFrame(altFrame),
    .serOutA(serOutA), .serOutB(serOutB), .railCode(railCode)
  );

  // Reference model, index 0 = entry column.
  logic [LEN-1:0]   mA = '0, mB = '0;
  logic [2*LEN-1:0] mLatch = '0;

  typedef struct {
    string       req;
    int          kind;   // 0 serOutA, 1 serOutB, 2 railCode
    logic [79:0] exp;
  } item_t;
  item_t sbq[$];

  int nApplied = 0;
  int nFail = 0;
  bit done = 1'b0;

  function automatic logic [79:0] codesFor(input logic [39:0] lat, input logic alt);
    logic [79:0] v;
    for (int k = 0; k < 40; k++) begin
      if (lat[k]) v[2*k +: 2] = alt ? 2'b11 : 2'b00;
      else        v[2*k +: 2] = alt ? 2'b10 : 2'b01;
    end
    return v;
  endfunction

  task automatic pushExp(input string req, input int kind, input logic [79:0] e);
    item_t it;
    it.req = req; it.kind = kind; it.exp = e;
    sbq.push_back(it);
  endtask

  // Drive point: 2 ns after a rising clk edge.
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic checkTaps(input string req);
    pushExp(req, 0, {79'b0, mA[LEN-1]});
    pushExp(req, 1, {79'b0, mB[LEN-1]});
  endtask

  task automatic checkRails(input string req);
    pushExp(req, 2, codesFor(mLatch, altFrame));
  endtask

  task automatic shiftPair(input logic a, input logic b);
    logic inB;
    step(); serInA = a; serInBDrv = b; shiftClk = 1'b1;
    step(); shiftClk = 1'b0;
    inB = chained ? mA[LEN-1] : b;
    step();
    mA = {mA[LEN-2:0], a};
    mB = {mB[LEN-2:0], inB};
  endtask

  task automatic loadPulse();
    step(); loadEn = 1'b1;
    step();
    step(); loadEn = 1'b0;
    mLatch = {mB, mA};
  endtask

  // Monitor: compare queued expectations at the falling clk edge.
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [79:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0:       act = {79'b0, serOutA};
        1:       act = {79'b0, serOutB};
        default: act = railCode;
      endcase
      nApplied++;
      if (act !== it.exp) begin
        nFail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nApplied, nFail);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (4) step();
    rstN = 1'b1;
    step();
    checkTaps("R9");
    checkRails("R9");
    step(); altFrame = 1'b1;
    checkRails("R9");
    step(); altFrame = 1'b0;

    // R1 R3 R4: split mode, first bit is 1 and reaches the tap after 20 shifts
    for (int i = 0; i < LEN; i++) begin
      shiftPair(i % 3 == 0, i % 2 == 1);
      checkTaps(i == LEN - 1 ? "R3" : "R1");
    end
    shiftPair(1'b0, 1'b1);
    checkTaps("R4");

    // R7 R8: latch and check all four rail codes
    loadPulse();
    checkRails("R8");
    step(); altFrame = 1'b1;
    checkRails("R7");

    // R6: shifting with load low leaves rails unchanged
    for (int i = 0; i < 5; i++) begin
      shiftPair(1'b1, 1'b1);
      checkRails("R6");
    end
    step(); altFrame = 1'b0;
    checkRails("R6");

    // R2: rising edge and a held-high level must not shift
    step(); serInA = 1'b1; serInBDrv = 1'b0; shiftClk = 1'b1;
    repeat (4) step();
    checkTaps("R2");
    loadPulse();
    checkRails("R2");
    step(); shiftClk = 1'b0;
    step();
    mA = {mA[LEN-2:0], 1'b1};
    mB = {mB[LEN-2:0], 1'b0};
    checkTaps("R2");

    // R5: latches transparent while shifting with load held high
    step(); loadEn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      shiftPair(i % 2 == 0, i % 3 == 0);
      step();
      mLatch = {mB, mA};
      checkRails("R5");
    end
    step(); loadEn = 1'b0;

    // R9: reset mid-run
    step(); rstN = 1'b0;
    step(); step(); rstN = 1'b1;
    mA = '0; mB = '0; mLatch = '0;
    step();
    checkTaps("R9");
    checkRails("R9");

    // R4: chained 40-stage mode
    step(); chained = 1'b1;
    for (int i = 0; i < 2 * LEN; i++) begin
      shiftPair(((i * 7) % 5) < 2, 1'b0);
      checkTaps("R4");
    end
    loadPulse();
    checkRails("R4");
    step(); altFrame = 1'b1;
    checkRails("R7");
    step(); chained = 1'b0;

    repeat (3) step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nFail);
    $finish;
  end

endmodule